// File: doc/BRIEF.md
# TLB Maintenance Controller

This block owns the entry array of a fully associative translation buffer and carries out the software-visible maintenance operations on it. Each entry holds a 64-bit tag and a 64-bit translation word. In the translation word, bit 63 is the valid flag, bits 62:61 give the page-size code and bit 6 is the lock flag. A separate tag-access register holds the tag that the next fill uses. The block also offers a read-only tag-target view of that register.

Operations are presented one at a time on a request port. Four operations exist. A load of the tag-access register. A fill, in which the block picks the slot. An indexed write. A demap, which scans the whole array one entry per cycle while `busy_o` is high. A combinational read port returns any entry's tag and translation word. The issuer takes the index from address bits 8:3, which is the low `IW` bits of that field. Whenever a valid entry is overwritten, the block emits a one-cycle invalidate pulse. The pulse carries the base and size code of the page that entry covered, so the downstream translation caches can be flushed. Translation lookup and fault recording are outside this block.

Top module: `tlbm_ctrl`

## Requirements
- R1: After reset, every entry's tag and translation word read as zero, the tag-access register is zero, and `busy_o` and `inv_valid_o` are low.
- R2: Operation code 3 loads `data_i` into the tag-access register at the clock edge that accepts it. `tag_target_o` always equals (tag_access[12:0] << 48) | (tag_access >> 22).
- R3: A fill (operation code 0) writes the tag-access value and `data_i` into the lowest-index entry whose valid bit (bit 63) is clear.
- R4: When no entry is invalid, a fill writes into the lowest-index entry whose lock bit (bit 6) is clear.
- R5: When every entry is both valid and locked, a fill changes no entry and raises no invalidate pulse.
- R6: An indexed write (operation code 1) writes the tag-access value and `data_i` into entry `wr_idx_i`, whatever that entry's state.
- R7: `rd_tag_o` and `rd_tte_o` show, combinationally, the tag and translation word of entry `rd_idx_i`.
- R8: A demap (operation code 2) zeroes both words of every valid entry whose tag equals `data_i` under that entry's page mask. The page mask is all ones above bit 12, shifted left by 3 bits per step of the size code. Invalid entries and non-matching entries are left unchanged.
- R9: A demap accepted at edge k holds `busy_o` high from edge k until edge k+ENTRIES. Entry i is processed at edge k+1+i. Requests presented while `busy_o` is high are ignored.
- R10: When a write replaces an entry that is valid, `inv_valid_o` is high for exactly the cycle after that edge. In that cycle, `inv_base_o` equals the old tag ANDed with the old page mask, and `inv_size_o` equals the old size code. Replacing an invalid entry raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Request strobe |
| op_i | input | 2 | 0 fill, 1 indexed write, 2 demap, 3 load tag access |
| wr_idx_i | input | IW | Entry index for an indexed write |
| data_i | input | 64 | Translation word, demap address or tag-access value |
| busy_o | output | 1 | Demap scan in progress; requests are ignored |
| rd_idx_i | input | IW | Entry index for reads |
| rd_tag_o | output | 64 | Tag of the entry being read |
| rd_tte_o | output | 64 | Translation word of the entry being read |
| tag_target_o | output | 64 | Tag-target view of the tag-access register |
| inv_valid_o | output | 1 | One-cycle invalidate pulse |
| inv_base_o | output | 64 | Base of the page range to invalidate |
| inv_size_o | output | 2 | Size code of the page range to invalidate |

## Verification
The bench builds the block with ENTRIES=8, so the whole array can be read back after every operation. This size also makes it cheap to fill every slot, to lock every slot, and to run a demap scan whose progress is checked entry by entry. The small array still exercises all four page-size codes. Each size code gets a demap address that matches under the large masks but not under the small ones. The bench also drives an ignored request in the middle of a scan.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  localparam int unsigned WORD_W   = 64;
  localparam int unsigned VALID_B  = 63;
  localparam int unsigned SIZE_LO  = 61;
  localparam int unsigned LOCK_B   = 6;

  typedef enum logic [1:0] {
    OP_FILL   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_DEMAP  = 2'd2,
    OP_TAGACC = 2'd3
  } op_e;

  function automatic logic [WORD_W-1:0] page_mask(input logic [1:0] sz);
    return 64'hFFFF_FFFF_FFFF_E000 << (3 * int'(sz));
  endfunction

  function automatic logic [WORD_W-1:0] tag_target(input logic [WORD_W-1:0] ta);
    return ({51'd0, ta[12:0]} << 48) | (ta >> 22);
  endfunction
endpackage

// File: rtl/tlbm_first.sv
module tlbm_first #(
  parameter int unsigned N  = 64,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlbm_store.sv
module tlbm_store
  import tlbm_pkg::*;
#(
  parameter int unsigned N  = 64,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IW-1:0]     widx_i,
  input  logic [WORD_W-1:0] wtag_i,
  input  logic [WORD_W-1:0] wtte_i,
  output logic [WORD_W-1:0] otag_o,
  output logic              ovalid_o,
  output logic [1:0]        osize_o,
  input  logic [IW-1:0]     ridx_i,
  output logic [WORD_W-1:0] rtag_o,
  output logic [WORD_W-1:0] rtte_o,
  output logic [N-1:0]      valid_o,
  output logic [N-1:0]      lock_o
);
  logic [WORD_W-1:0] tag_q [N];
  logic [WORD_W-1:0] tte_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[g] <= '0;
        tte_q[g] <= '0;
      end else if (we_i && (widx_i == IW'(g))) begin
        tag_q[g] <= wtag_i;
        tte_q[g] <= wtte_i;
      end
    end
    assign valid_o[g] = tte_q[g][VALID_B];
    assign lock_o[g]  = tte_q[g][LOCK_B];
  end

  assign otag_o   = tag_q[widx_i];
  assign ovalid_o = tte_q[widx_i][VALID_B];
  assign osize_o  = tte_q[widx_i][SIZE_LO+:2];
  assign rtag_o   = tag_q[ridx_i];
  assign rtte_o   = tte_q[ridx_i];

  assert_write_lands_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (tte_q[$past(widx_i)] == $past(wtte_i)) && (tag_q[$past(widx_i)] == $past(wtag_i)));
endmodule

// File: rtl/tlbm_ctrl.sv
module tlbm_ctrl
  import tlbm_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IW = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [1:0]        op_i,
  input  logic [IW-1:0]     wr_idx_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              busy_o,
  input  logic [IW-1:0]     rd_idx_i,
  output logic [WORD_W-1:0] rd_tag_o,
  output logic [WORD_W-1:0] rd_tte_o,
  output logic [WORD_W-1:0] tag_target_o,
  output logic              inv_valid_o,
  output logic [WORD_W-1:0] inv_base_o,
  output logic [1:0]        inv_size_o
);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [WORD_W-1:0] tagacc_q, dm_addr_q, inv_base_q;
  logic              busy_q, inv_valid_q;
  logic [IW-1:0]     scan_q;
  logic [1:0]        inv_size_q;

  logic              we;
  logic [IW-1:0]     widx;
  logic [WORD_W-1:0] wtag, wtte, otag;
  logic              ovalid;
  logic [1:0]        osize;
  logic [ENTRIES-1:0] valid_vec, lock_vec;
  logic              free_any, unl_any, accept, dm_hit;
  logic [IW-1:0]     free_idx, unl_idx;

  tlbm_store #(.N(ENTRIES), .IW(IW)) u_store (
    .clk_i, .rst_ni,
    .we_i(we), .widx_i(widx), .wtag_i(wtag), .wtte_i(wtte),
    .otag_o(otag), .ovalid_o(ovalid), .osize_o(osize),
    .ridx_i(rd_idx_i), .rtag_o(rd_tag_o), .rtte_o(rd_tte_o),
    .valid_o(valid_vec), .lock_o(lock_vec)
  );

  tlbm_first #(.N(ENTRIES), .IW(IW)) u_free (
    .req_i(~valid_vec), .found_o(free_any), .idx_o(free_idx));
  tlbm_first #(.N(ENTRIES), .IW(IW)) u_unl (
    .req_i(~lock_vec), .found_o(unl_any), .idx_o(unl_idx));

  assign accept = op_valid_i && !busy_q;
  assign dm_hit = ovalid && (((dm_addr_q ^ otag) & page_mask(osize)) == '0);

  always_comb begin
    we   = 1'b0;
    widx = scan_q;
    wtag = '0;
    wtte = '0;
    if (busy_q) begin
      we = dm_hit;
    end else if (accept) begin
      unique case (op_e'(op_i))
        OP_FILL: begin
          we   = free_any || unl_any;
          widx = free_any ? free_idx : unl_idx;
          wtag = tagacc_q;
          wtte = data_i;
        end
        OP_WRITE: begin
          we   = 1'b1;
          widx = wr_idx_i;
          wtag = tagacc_q;
          wtte = data_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tagacc_q  <= '0;
      dm_addr_q <= '0;
      busy_q    <= 1'b0;
      scan_q    <= '0;
    end else if (busy_q) begin
      scan_q <= scan_q + 1'b1;
      if (scan_q == LAST) busy_q <= 1'b0;
    end else if (accept) begin
      if (op_e'(op_i) == OP_TAGACC) tagacc_q <= data_i;
      if (op_e'(op_i) == OP_DEMAP) begin
        dm_addr_q <= data_i;
        busy_q    <= 1'b1;
        scan_q    <= '0;
      end
    end
  end

  // flush request for the page range a valid entry covered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_valid_q <= 1'b0;
      inv_base_q  <= '0;
      inv_size_q  <= '0;
    end else begin
      inv_valid_q <= we && ovalid;
      if (we && ovalid) begin
        inv_base_q <= otag & page_mask(osize);
        inv_size_q <= osize;
      end
    end
  end

  assign busy_o       = busy_q;
  assign tag_target_o = tag_target(tagacc_q);
  assign inv_valid_o  = inv_valid_q;
  assign inv_base_o   = inv_base_q;
  assign inv_size_o   = inv_size_q;

  assert_fill_free_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op_i == 2'd0 && free_any) |-> (we && !valid_vec[widx]));
  assert_fill_unlocked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op_i == 2'd0 && !free_any && unl_any) |-> (we && !lock_vec[widx]));
  assert_fill_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op_i == 2'd0 && (&valid_vec) && (&lock_vec)) |-> !we);
  assert_demap_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && we) |=> !valid_vec[$past(scan_q)]);
  assert_busy_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(op_valid_i && op_i == 2'd2));
  assert_busy_holds_tagacc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(tagacc_q));
  assert_inv_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |-> $past(we));
endmodule

// File: tb/tlbm_ctrl_test.sv
`timescale 1ns/1ps
module tlbm_ctrl_test;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [1:0] op = 2'd0;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0;
  logic [63:0] data = '0;
  logic busy, inv_valid;
  logic [63:0] rd_tag, rd_tte, tgt, inv_base;
  logic [1:0] inv_size;

  tlbm_ctrl #(.ENTRIES(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op),
    .wr_idx_i(wr_idx), .data_i(data), .busy_o(busy), .rd_idx_i(rd_idx),
    .rd_tag_o(rd_tag), .rd_tte_o(rd_tte), .tag_target_o(tgt),
    .inv_valid_o(inv_valid), .inv_base_o(inv_base), .inv_size_o(inv_size));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] mtag [N];
  logic [63:0] mtte [N];
  logic [63:0] mta;
  logic        e_iv;
  logic [63:0] e_base;
  logic [1:0]  e_sz;

  function automatic logic [63:0] pmask(input logic [1:0] s);
    logic [63:0] m = 64'hFFFF_FFFF_FFFF_E000;
    for (int k = 0; k < int'(s); k++) m = m << 3;
    return m;
  endfunction

  function automatic logic [63:0] mk(input bit v, input logic [1:0] s, input bit lk, input logic [63:0] pa);
    return ({63'd0, v} << 63) | ({62'd0, s} << 61) | (pa & 64'h0000_01FF_FFFF_E000) | ({63'd0, lk} << 6);
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic chk_all(input string r);
    for (int i = 0; i < N; i++) begin
      rd_idx = IW'(i);
      #0.1;
      chk({r, " tag"}, rd_tag, mtag[i]);
      chk({r, " tte"}, rd_tte, mtte[i]);
    end
  endtask

  task automatic chk_inv(input string r);
    chk({r, " inv_valid"}, {63'd0, inv_valid}, {63'd0, e_iv});
    if (e_iv) begin
      chk({r, " inv_base"}, inv_base, e_base);
      chk({r, " inv_size"}, {62'd0, inv_size}, {62'd0, e_sz});
    end
  endtask

  task automatic expect_replace(input int i);
    e_iv = mtte[i][63];
    e_base = mtag[i] & pmask(mtte[i][62:61]);
    e_sz = mtte[i][62:61];
  endtask

  task automatic issue(input logic [1:0] o, input int idx, input logic [63:0] d);
    @(negedge clk);
    op_valid = 1'b1; op = o; wr_idx = IW'(idx); data = d;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic set_ta(input logic [63:0] v);
    issue(2'd3, 0, v);
    mta = v;
    chk("R2 tag_target", tgt, ({51'd0, v[12:0]} << 48) | (v >> 22));
  endtask

  task automatic wr(input string r, input int i, input logic [63:0] t);
    expect_replace(i);
    issue(2'd1, i, t);
    chk_inv(r);
    mtag[i] = mta; mtte[i] = t;
    chk_all(r);
  endtask

  task automatic fill(input string r, input logic [63:0] t);
    int s = -1;
    for (int i = N - 1; i >= 0; i--) if (!mtte[i][6]) s = i;
    for (int i = N - 1; i >= 0; i--) if (!mtte[i][63]) s = i;
    if (s >= 0) expect_replace(s); else e_iv = 1'b0;
    issue(2'd0, 0, t);
    chk_inv(r);
    if (s >= 0) begin mtag[s] = mta; mtte[s] = t; end
    chk_all(r);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin mtag[i] = '0; mtte[i] = '0; end
    mta = '0; e_iv = 0; e_base = '0; e_sz = '0;
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 inv", {63'd0, inv_valid}, 64'd0);
    chk("R1 tag_target", tgt, 64'd0);
    chk_all("R1");

    // R2 tag target over several patterns
    set_ta(64'hFFFF_FFFF_FFFF_FFFF);
    set_ta(64'h0000_0000_0000_1FFF);
    set_ta(64'hA5A5_5A5A_C3C3_3C3C);
    set_ta(64'h0000_0000_0040_0000);

    // R3 fills land in ascending free slots; even slots locked
    for (int i = 0; i < N; i++) begin
      set_ta(64'h0000_0100_0000_0000 + (64'(i) << 16) + 64'(i + 1));
      fill("R3 fill free", mk(1, 2'(i % 4), (i % 2) == 0, 64'h10_0000 * 64'(i + 1)));
    end
    // R6/R10 indexed write over a valid entry
    set_ta(64'h0000_0000_0777_0000);
    wr("R6 R10 write valid", 3, 64'd0);
    // R3 fill takes the single free slot
    set_ta(64'h0000_0000_0888_2003);
    fill("R3 fill hole", mk(1, 2'd2, 1, 64'h5000_0000));
    // R4 all valid: lowest unlocked (slot 1), pulse carries old page
    set_ta(64'h0000_0000_0999_4004);
    fill("R4 R10 fill unlocked", mk(1, 2'd0, 0, 64'h6000_0000));
    // lock everything, then R5 fill dropped
    for (int i = 0; i < N; i++) begin
      set_ta(64'h0000_0002_0000_0000 + (64'(i) << 13));
      wr("R6 lock all", i, mk(1, 2'(i % 4), 1, 64'h7000_0000));
    end
    fill("R5 fill dropped", mk(1, 2'd1, 0, 64'h8000_0000));

    // R8 demap set-up
    set_ta(64'h0000_0000_1000_2005); wr("R8 setup", 0, mk(1, 2'd0, 0, 64'h1_0000));
    set_ta(64'h0000_0000_1000_4000); wr("R8 setup", 1, mk(1, 2'd1, 0, 64'h2_0000));
    set_ta(64'h0000_0000_1003_0000); wr("R8 setup", 2, mk(1, 2'd2, 0, 64'h3_0000));
    set_ta(64'h0000_0000_1040_0000); wr("R8 setup", 3, mk(1, 2'd3, 0, 64'h4_0000));
    set_ta(64'h0000_0000_2000_0000); wr("R8 setup", 4, mk(1, 2'd0, 0, 64'h5_0000));
    set_ta(64'h0000_0000_1000_2000); wr("R8 setup", 5, mk(0, 2'd0, 0, 64'h6_0000));
    set_ta(64'h0000_0000_1000_0000); wr("R8 setup", 6, mk(1, 2'd3, 1, 64'h7_0000));
    set_ta(64'h0000_0000_1000_2011); wr("R6 R8 setup", 7, mk(1, 2'd0, 0, 64'h8_0000));

    // R8/R9 demap scan, with an ignored write during the scan
    e_iv = 0;
    issue(2'd2, 0, 64'h0000_0000_1000_2000);
    chk("R9 busy rise", {63'd0, busy}, 64'd1);
    chk_inv("R9 capture");
    for (int i = 0; i < N; i++) begin
      logic hit;
      if (i == 2) begin op_valid = 1'b1; op = 2'd1; wr_idx = 3'd4; data = 64'hDEAD; end
      hit = mtte[i][63] && (((64'h0000_0000_1000_2000 ^ mtag[i]) & pmask(mtte[i][62:61])) == 64'd0);
      if (hit) expect_replace(i); else e_iv = 1'b0;
      @(posedge clk);
      @(negedge clk);
      op_valid = 1'b0;
      chk_inv("R8 R10 demap step");
      if (hit) begin mtag[i] = '0; mtte[i] = '0; end
      chk("R9 busy during scan", {63'd0, busy}, {63'd0, i != N - 1});
    end
    chk_all("R8 R9 after demap");
    // R10 write into an invalid entry: no pulse
    wr("R10 invalid replace", 5, mk(1, 2'd1, 0, 64'h9_0000));
    // R7 read index sweep already applied in chk_all; single extra read
    rd_idx = 3'd6; #0.1;
    chk("R7 read tte", rd_tte, mtte[6]);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule